// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block converts a 21-bit parallel pixel word into four serial lanes for a flat-panel link. Eighteen bits carry colour and three carry panel timing: horizontal sync, vertical sync and data enable. The block runs on a bit clock at seven times the pixel rate. It watches the incoming pixel clock as a sampled signal. On the selected pixel-clock edge it captures the word. Three data lanes then each send seven of its bits during the next pixel period. A fourth lane sends a fixed framing pattern that lets the far end find word boundaries.

A static select input chooses whether the word is taken on the rising or the falling pixel-clock transition. All four lanes are forced low in two cases: while power-down is held, and while the pixel clock is judged to be missing. The clock counts as missing after a long run of bit-clock cycles with no pixel-clock transition. Output comes back only after two capture edges have been seen again. The block is built for pixel rates of 18 to 87.5 MHz, which gives up to 612.5 Mbit/s per lane. The analog drivers and the bit-clock PLL sit outside it.

Top module: `pixlink_ser7`

## Requirements
- R1: While reset is high, and after it until the pixel clock has been qualified, all four lanes are 0.
- R2: With `strobe_rise`=1, `pix_data` is captured at the first bit-clock edge where `pix_clk` is sampled 1 after being sampled 0 at the previous edge.
- R3: With `strobe_rise`=0, `pix_data` is captured at the first bit-clock edge where `pix_clk` is sampled 0 after being sampled 1 at the previous edge.
- R4: Lane k (k=0,1,2, driven on `lane_o[k]`) carries word bits 7k+6 down to 7k, with bit 7k+6 first.
- R5: `lane_o[3]` repeats 1,1,0,0,0,1,1 in every seven-cycle frame, and its first 1 is aligned with the first data bit of each frame.
- R6: Frames are seven bit-clock cycles long and start at a fixed cadence from reset, the first one at the seventh edge. Each frame takes the whole word held at its start, so a capture during a frame only shows in the next frame.
- R7: While `pwr_down` is 1, all lanes are 0 in the same cycle. Capture and framing continue underneath, so the stream resumes in step when `pwr_down` returns to 0.
- R8: After 32 consecutive bit-clock edges with no change of `pix_clk`, all lanes are 0.
- R9: After the clock is judged missing, output resumes at the second capture edge (per R2/R3) that follows.
- R10: A pause in `pix_clk` of fewer than 32 bit-clock edges does not gate the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled on clk_bit |
| pix_data | input | 21 | Parallel pixel word |
| strobe_rise | input | 1 | 1: capture on rising pix_clk, 0: on falling |
| pwr_down | input | 1 | Forces all lanes low |
| lane_o | output | 4 | Serial lanes; [2:0] data, [3] framing clock |

## Verification
The hardest situation to reach is the one where capture edges fall partway through a frame while the clock stalls and recovers. The stimulus first inserts idle gaps of uneven length in front of pixel bursts. This moves the capture edge to several phases of the frame. It then holds `pix_clk` still for 20 cycles, which must not gate, and for 40 cycles, which must gate. Restarting the clock after the long hold shows the two-edge recovery, and the whole sequence is repeated with falling-edge capture.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

    localparam int unsigned DATA_LANES    = 3;
    localparam int unsigned BITS_PER_LANE = 7;
    localparam int unsigned WORD_W        = DATA_LANES * BITS_PER_LANE;
    localparam int unsigned IDLE_LIMIT    = 32;
    localparam logic [BITS_PER_LANE-1:0] FRAME_PATTERN = 7'b1100011;

    typedef logic [WORD_W-1:0] pix_word_t;

    typedef struct packed {
        logic strobe;    // selected capture transition
        logic toggled;   // any transition of the pixel clock
    } pix_event_t;

    function automatic logic [BITS_PER_LANE-1:0] lane_slice(input pix_word_t w, input int unsigned k);
        return w[k*BITS_PER_LANE +: BITS_PER_LANE];
    endfunction

endpackage

// File: rtl/pixlink_capture.sv
module pixlink_capture
    import pixlink_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pix_clk,
    input  logic         strobe_rise,
    input  logic [W-1:0] pix_data,
    output pix_event_t   ev,
    output logic [W-1:0] hold_word
);

    logic pix_q;

    always_comb begin
        ev.toggled = pix_clk ^ pix_q;
        ev.strobe  = strobe_rise ? (pix_clk & ~pix_q) : (~pix_clk & pix_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q     <= 1'b0;
            hold_word <= '0;
        end else begin
            pix_q <= pix_clk;
            if (ev.strobe) begin
                hold_word <= pix_data;
            end
        end
    end

endmodule

// File: rtl/pixlink_clkwatch.sv
module pixlink_clkwatch
    import pixlink_pkg::*;
#(
    parameter int unsigned LIMIT = IDLE_LIMIT
) (
    input  logic       clk,
    input  logic       rst,
    input  pix_event_t ev,
    output logic       missing
);

    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] idle_cnt;
    logic          good_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt  <= '0;
            good_seen <= 1'b0;
            missing   <= 1'b1;
        end else begin
            if (ev.toggled) begin
                idle_cnt <= '0;
            end else if (idle_cnt != CW'(LIMIT)) begin
                idle_cnt <= idle_cnt + 1'b1;
            end

            if (!ev.toggled && idle_cnt == CW'(LIMIT - 1)) begin
                missing   <= 1'b1;
                good_seen <= 1'b0;
            end else if (missing && ev.strobe) begin
                if (good_seen) begin
                    missing   <= 1'b0;
                    good_seen <= 1'b0;
                end else begin
                    good_seen <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pixlink_shifter.sv
module pixlink_shifter #(
    parameter int unsigned        W       = 7,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         ser
);

    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= RST_VAL;
        end else if (load) begin
            sh <= load_val;
        end else begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign ser = sh[W-1];

endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7
    import pixlink_pkg::*;
#(
    parameter int unsigned LANES = DATA_LANES,
    parameter int unsigned BPL   = BITS_PER_LANE,
    parameter int unsigned LIMIT = IDLE_LIMIT
) (
    input  logic                  clk_bit,
    input  logic                  rst,
    input  logic                  pix_clk,
    input  logic [LANES*BPL-1:0]  pix_data,
    input  logic                  strobe_rise,
    input  logic                  pwr_down,
    output logic [LANES:0]        lane_o
);

    localparam int unsigned W    = LANES * BPL;
    localparam int unsigned PH_W = $clog2(BPL);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(BPL - 1);

    pix_event_t     ev;
    logic [W-1:0]   hold_word;
    logic           clk_missing;
    logic [PH_W-1:0] phase;
    logic           frame_load;
    logic [LANES:0] ser_raw;

    pixlink_capture #(.W(W)) u_cap (
        .clk        (clk_bit),
        .rst        (rst),
        .pix_clk    (pix_clk),
        .strobe_rise(strobe_rise),
        .pix_data   (pix_data),
        .ev         (ev),
        .hold_word  (hold_word)
    );

    pixlink_clkwatch #(.LIMIT(LIMIT)) u_watch (
        .clk    (clk_bit),
        .rst    (rst),
        .ev     (ev),
        .missing(clk_missing)
    );

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            phase <= '0;
        end else if (frame_load) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign frame_load = (phase == LAST_PH);

    for (genvar k = 0; k < LANES; k++) begin : g_data
        pixlink_shifter #(.W(BPL), .RST_VAL('0)) u_sh (
            .clk     (clk_bit),
            .rst     (rst),
            .load    (frame_load),
            .load_val(hold_word[k*BPL +: BPL]),
            .ser     (ser_raw[k])
        );
    end

    pixlink_shifter #(.W(BPL), .RST_VAL(FRAME_PATTERN)) u_frame (
        .clk     (clk_bit),
        .rst     (rst),
        .load    (frame_load),
        .load_val(FRAME_PATTERN),
        .ser     (ser_raw[LANES])
    );

    assign lane_o = (pwr_down || clk_missing) ? '0 : ser_raw;

endmodule

// File: rtl/pixlink_ser7_chk.sv
module pixlink_ser7_chk
    import pixlink_pkg::*;
#(
    parameter int unsigned LANES = DATA_LANES,
    parameter int unsigned BPL   = BITS_PER_LANE,
    parameter int unsigned LIMIT = IDLE_LIMIT
) (
    input logic                 clk_bit,
    input logic                 rst,
    input logic                 pix_clk,
    input logic                 strobe_rise,
    input logic                 pwr_down,
    input logic [LANES:0]       lane_o,
    input logic [LANES*BPL-1:0] hold_word,
    input logic                 clk_missing,
    input logic                 frame_load
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam int unsigned GW = $clog2(BPL + 1);

    logic          prev_pix;
    logic          strobe_seen;
    logic [CW-1:0] quiet;
    logic [GW-1:0] since_load;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            prev_pix    <= 1'b0;
            strobe_seen <= 1'b0;
            quiet       <= '0;
            since_load  <= '0;
        end else begin
            prev_pix    <= pix_clk;
            strobe_seen <= strobe_rise ? (pix_clk && !prev_pix) : (!pix_clk && prev_pix);
            if (pix_clk != prev_pix) quiet <= '0;
            else if (quiet != CW'(LIMIT)) quiet <= quiet + 1'b1;
            since_load  <= frame_load ? '0 : since_load + 1'b1;
        end
    end

    // R7
    pd_gate_chk: assert property (@(posedge clk_bit) disable iff (rst)
        pwr_down |-> lane_o == '0);

    // R8
    idle_gate_chk: assert property (@(posedge clk_bit) disable iff (rst)
        (quiet == CW'(LIMIT)) |-> lane_o == '0);

    // R2
    hold_capture_chk: assert property (@(posedge clk_bit) disable iff (rst)
        !$stable(hold_word) |-> strobe_seen);

    // R6
    frame_cadence_chk: assert property (@(posedge clk_bit) disable iff (rst)
        frame_load |-> since_load == GW'(BPL - 1));

    // R9
    resume_edge_chk: assert property (@(posedge clk_bit) disable iff (rst)
        $fell(clk_missing) |-> strobe_seen);

endmodule

bind pixlink_ser7 pixlink_ser7_chk #(.LANES(LANES), .BPL(BPL), .LIMIT(LIMIT)) u_chk (
    .clk_bit    (clk_bit),
    .rst        (rst),
    .pix_clk    (pix_clk),
    .strobe_rise(strobe_rise),
    .pwr_down   (pwr_down),
    .lane_o     (lane_o),
    .hold_word  (hold_word),
    .clk_missing(clk_missing),
    .frame_load (frame_load)
);

// File: tb/pixlink_ser7_bench.sv
module pixlink_ser7_bench;

    logic        clk_bit = 1'b0;
    logic        rst = 1'b1;
    logic        pix_clk = 1'b0;
    logic [20:0] pix_data = '0;
    logic        strobe_rise = 1'b1;
    logic        pwr_down = 1'b0;
    logic [3:0]  lane_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    string cur_tag = "R1";

    // reference state
    int m_prev, m_idle, m_missing, m_good, m_phase;
    logic [20:0] m_hold, m_word;
    localparam logic [6:0] PAT = 7'b1100011;

    always #5 clk_bit = ~clk_bit;

    pixlink_ser7 u_pixlink_ser7 (
        .clk_bit    (clk_bit),
        .rst        (rst),
        .pix_clk    (pix_clk),
        .pix_data   (pix_data),
        .strobe_rise(strobe_rise),
        .pwr_down   (pwr_down),
        .lane_o     (lane_o)
    );

    task automatic model_reset();
        m_prev = 0; m_idle = 0; m_missing = 1; m_good = 0; m_phase = 0;
        m_hold = '0; m_word = '0;
    endtask

    // one bit-clock edge: advance the reference, then compare at the negedge
    task automatic tick();
        int p, strobe, tog;
        logic [3:0] exp_l;
        @(negedge clk_bit);
        if (rst) begin
            model_reset();
        end else begin
            p      = int'(pix_clk);
            tog    = (p != m_prev);
            strobe = strobe_rise ? (p == 1 && m_prev == 0) : (p == 0 && m_prev == 1);
            if (!tog && m_idle == 31) begin
                m_missing = 1; m_good = 0;
            end else if (m_missing == 1 && strobe == 1) begin
                if (m_good == 1) begin m_missing = 0; m_good = 0; end
                else m_good = 1;
            end
            if (tog) m_idle = 0;
            else if (m_idle < 32) m_idle++;
            if (m_phase == 6) begin m_phase = 0; m_word = m_hold; end
            else m_phase++;
            if (strobe == 1) m_hold = pix_data;
            m_prev = p;
        end
        exp_l = '0;
        if (!rst && !pwr_down && m_missing == 0) begin
            for (int k = 0; k < 3; k++) exp_l[k] = m_word[7*k + 6 - m_phase];
            exp_l[3] = PAT[6 - m_phase];
        end
        n_checks++;
        if (lane_o !== exp_l) begin
            n_fail++;
            $display("FAIL %s lane_o=%b expected=%b at %0t", cur_tag, lane_o, exp_l, $time);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // pixel periods of 7 bit clocks, high for 4, low for 3
    task automatic pixels(input int n, input bit churn);
        for (int j = 0; j < n; j++) begin
            for (int c = 0; c < 7; c++) begin
                pix_clk = (c < 4);
                if (c == 0) pix_data = 21'($urandom);
                if (churn && c == 2) pix_data = 21'($urandom);
                tick();
            end
        end
    endtask

    task automatic do_reset(input bit rise);
        rst = 1'b1; strobe_rise = rise; pix_clk = 1'b0; pwr_down = 1'b0;
        cur_tag = "R1";
        idle_cycles(3);
        rst = 1'b0;
        idle_cycles(4);
    endtask

    initial begin
        model_reset();
        do_reset(1'b1);

        cur_tag = "R2";  pixels(6, 1'b0);
        cur_tag = "R4";  pixels(6, 1'b0);
        cur_tag = "R5";  pixels(4, 1'b0);

        cur_tag = "R6";
        idle_cycles(3); pixels(4, 1'b1);
        idle_cycles(5); pixels(4, 1'b1);

        cur_tag = "R7";
        pwr_down = 1'b1; pixels(2, 1'b0);
        pwr_down = 1'b0; pixels(3, 1'b0);

        cur_tag = "R10"; idle_cycles(20); pixels(4, 1'b0);
        cur_tag = "R8";  idle_cycles(40);
        cur_tag = "R9";  pixels(5, 1'b0);

        do_reset(1'b0);
        cur_tag = "R3";
        pixels(6, 1'b1);
        idle_cycles(2); pixels(4, 1'b0);
        cur_tag = "R8";  pix_clk = 1'b1; idle_cycles(36);
        cur_tag = "R9";  pixels(4, 1'b0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_bit);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule